// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

This controller moves data between a volatile SRAM array and the nonvolatile copy behind it. It does not model either array. A transfer is a busy window of a fixed number of clock cycles, and a strobe marks the end of it. Three sources can start a transfer:

- **Software sequence.** Six enable-qualified reads to a fixed list of addresses start a STORE or a RECALL.
- **Supply rise.** The supply-good flag going high starts an automatic RECALL.
- **Supply fall.** The flag going low starts an automatic STORE, but only when the array holds data written since the last transfer.

While a transfer runs, the controller ignores the bus. It also blocks SRAM writes whenever it is busy or the supply is below threshold. All inputs are sampled on `clk`, and the supply flag is assumed to be synchronized already. A bus cycle is recognised at the first clock edge that sees `ce_n` low after it was high. `we_n` is sampled at that same edge to tell a read from a write.

Top module: `nvsram_xfer_ctrl`

## Requirements
- R1: Six reads to the addresses SEQ_A0, SEQ_A1, SEQ_A2, SEQ_A3, SEQ_A4 and then SEQ_STO start a STORE. The same five reads followed by SEQ_REC start a RECALL. `busy` is high from the clock edge that registers the sixth read. One enable-low cycle is enough to make a read.
- R2: A write cycle (`we_n` low when the enable falls) neither advances nor resets the software sequence.
- R3: Two reads in a row from the same address return the sequence to its start. So does a read from an address that is not the next one expected.
- R4: `busy` stays high for exactly STORE_CYCLES cycles for a STORE and RECALL_CYCLES cycles for a RECALL.
- R5: While `busy` is high, bus cycles are ignored. They start no further transfer, and the sequence starts afresh after the transfer.
- R6: A software STORE is not started while `vcc_ok` is low. A software RECALL runs regardless of `vcc_ok`.
- R7: Every low-to-high change of `vcc_ok` starts an automatic RECALL. This covers both the first power-up and the return from a brown-out.
- R8: A high-to-low change of `vcc_ok` starts an automatic STORE only if a write was accepted since the end of the last transfer.
- R9: `wr_block` is high whenever `busy` is high or `vcc_ok` is low, and low otherwise. A write made while `wr_block` is high does not mark the array as changed.
- R10: Exactly one of `done_store` and `done_recall` goes high, for one cycle, in the first cycle after `busy` falls. It names the kind of transfer that ended.
- R11: When a supply rise and a completed software RECALL land in the same cycle, a single RECALL runs. A supply change that arrives during a transfer is held back and served right after the transfer, if the supply is still in the same state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its falling edge marks a bus cycle |
| we_n | input | 1 | Write enable, active low, sampled with the enable fall |
| addr | input | ADDR_W | Bus address |
| vcc_ok | input | 1 | High while the supply is above the switch threshold |
| busy | output | 1 | High while a transfer runs |
| wr_block | output | 1 | High while SRAM writes must be suppressed |
| done_store | output | 1 | One-cycle strobe when a STORE ends |
| done_recall | output | 1 | One-cycle strobe when a RECALL ends |

## Verification
Two cases let triggers collide.

- **Same cycle.** The supply-good flag rises on the same clock edge that registers the sixth read of a RECALL sequence. The bench counts completed transfers and expects exactly one RECALL of the RECALL length.
- **During a transfer.** The flag rises a few cycles into a brown-out STORE. The bench expects a STORE strobe, then at once a RECALL, with both windows at their full length.

The random phase compares every read with a bench model of the sequence. This covers sequence completion, repeated-address aborts and interleaved writes.

// File: rtl/nvsram_xfer_ctrl.sv
module nvsram_xfer_ctrl #(
  parameter int ADDR_W        = 15,
  parameter int STORE_CYCLES  = 2000,
  parameter int RECALL_CYCLES = 40,
  parameter logic [ADDR_W-1:0] SEQ_A0  = 15'h0E38,
  parameter logic [ADDR_W-1:0] SEQ_A1  = 15'h31C7,
  parameter logic [ADDR_W-1:0] SEQ_A2  = 15'h03E0,
  parameter logic [ADDR_W-1:0] SEQ_A3  = 15'h3C1F,
  parameter logic [ADDR_W-1:0] SEQ_A4  = 15'h303F,
  parameter logic [ADDR_W-1:0] SEQ_STO = 15'h0FC0,
  parameter logic [ADDR_W-1:0] SEQ_REC = 15'h0C63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vcc_ok,
  output logic              busy,
  output logic              wr_block,
  output logic              done_store,
  output logic              done_recall
);
  localparam int MAXC  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [CNT_W-1:0] STO_LOAD = CNT_W'(STORE_CYCLES - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(RECALL_CYCLES - 1);

  logic              ce_q, vcc_q, dirty, kind_sto, pend_sto, pend_rec, last_v;
  logic [2:0]        step;
  logic [ADDR_W-1:0] last_a;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [ADDR_W-1:0] seq_at(input logic [2:0] s);
    case (s)
      3'd0:    return SEQ_A0;
      3'd1:    return SEQ_A1;
      3'd2:    return SEQ_A2;
      3'd3:    return SEQ_A3;
      default: return SEQ_A4;
    endcase
  endfunction

  wire ce_fall  = ce_q & ~ce_n & ~busy;
  wire rd_fall  = ce_fall & we_n;
  wire wr_ok    = ce_fall & ~we_n & vcc_ok;
  wire rep      = last_v && (addr == last_a);
  wire fin      = rd_fall & ~rep & (step == 3'd5);
  wire sw_sto   = fin & (addr == SEQ_STO);
  wire sw_rec   = fin & (addr == SEQ_REC);
  wire vrise    = vcc_ok & ~vcc_q;
  wire vfall    = ~vcc_ok & vcc_q;
  wire want_sto = (pend_sto | (vfall & dirty)) & ~vcc_ok;
  wire want_rec = (pend_rec | vrise) & vcc_ok;
  wire go_sto   = ~busy & (want_sto | (sw_sto & vcc_ok & ~want_rec));
  wire go_rec   = ~busy & ~want_sto & (want_rec | sw_rec);
  wire last_cyc = busy && (cnt == '0);

  assign wr_block = busy | ~vcc_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;  vcc_q <= 1'b0;  dirty <= 1'b0;
      pend_sto <= 1'b0;  pend_rec <= 1'b0;
      busy <= 1'b0;  kind_sto <= 1'b0;  cnt <= '0;
      done_store <= 1'b0;  done_recall <= 1'b0;
    end else begin
      ce_q     <= ce_n;
      vcc_q    <= vcc_ok;
      pend_sto <= want_sto & ~go_sto;
      pend_rec <= want_rec & ~go_rec;
      if (last_cyc)   dirty <= 1'b0;
      else if (wr_ok) dirty <= 1'b1;
      done_store  <= last_cyc & kind_sto;
      done_recall <= last_cyc & ~kind_sto;
      if (go_sto | go_rec) begin
        busy     <= 1'b1;
        kind_sto <= go_sto;
        cnt      <= go_sto ? STO_LOAD : REC_LOAD;
      end else if (last_cyc) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;  last_a <= '0;  last_v <= 1'b0;
    end else if (go_sto | go_rec) begin
      step <= '0;  last_v <= 1'b0;
    end else if (rd_fall) begin
      last_a <= addr;
      last_v <= 1'b1;
      if (rep || step == 3'd5)        step <= '0;
      else if (addr == seq_at(step))  step <= step + 3'd1;
      else                            step <= '0;
    end
  end

  // R4 / R5: a running transfer is never cut short
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != '0 |=> busy);
  // R7
  p_rise_recall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_ok) && !busy |=> busy && !kind_sto);
  // R10
  p_done_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_store ^ done_recall));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_store || done_recall) |-> !busy && $past(busy));
  // R9
  p_dirty_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty) |-> $past(vcc_ok && !busy));
  // R6: a store begun with the supply low is always the automatic one
  p_store_inh_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && kind_sto && !$past(vcc_ok) |-> $past(pend_sto || vcc_q));
endmodule

// File: tb/nvsram_xfer_ctrl_tb.sv
module nvsram_xfer_ctrl_tb;
  localparam int SC = 40;
  localparam int RC = 12;
  localparam logic [14:0] A0 = 15'h0E38, A1 = 15'h31C7, A2 = 15'h03E0,
                          A3 = 15'h3C1F, A4 = 15'h303F,
                          AS = 15'h0FC0, AR = 15'h0C63;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, vcc_ok = 0;
  logic [14:0] addr = '0;
  logic busy, wr_block, done_store, done_recall;

  int total = 0, bad = 0;
  int run = 0, last_len = 0, xfers = 0, last_kind = 0, prev_kind = 0;
  int ms = 0;
  logic [14:0] ml = '0;
  bit mv = 0;

  nvsram_xfer_ctrl #(.ADDR_W(15), .STORE_CYCLES(SC), .RECALL_CYCLES(RC),
    .SEQ_A0(A0), .SEQ_A1(A1), .SEQ_A2(A2), .SEQ_A3(A3), .SEQ_A4(A4),
    .SEQ_STO(AS), .SEQ_REC(AR)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .vcc_ok(vcc_ok), .busy(busy), .wr_block(wr_block),
    .done_store(done_store), .done_recall(done_recall));

  always #5ns clk = ~clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // transfer monitor: length, kind and strobe timing (R4, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run++;
      else if (run > 0) begin
        last_len = run;
        run = 0;
        xfers++;
        prev_kind = last_kind;
        last_kind = done_store ? 1 : (done_recall ? 2 : 0);
        chk(done_store ^ done_recall, "R10 strobe at busy fall", {done_store, done_recall}, 1);
      end else if (done_store || done_recall) begin
        chk(0, "R10 spurious strobe", {done_store, done_recall}, 0);
      end
    end
  end

  function automatic logic [14:0] seq_at(input int s);
    case (s)
      0: return A0;
      1: return A1;
      2: return A2;
      3: return A3;
      default: return A4;
    endcase
  endfunction

  function automatic int model_read(input logic [14:0] a);
    int k = 0;
    if (mv && a == ml) ms = 0;
    else if (ms == 5) begin
      k = (a == AS) ? 1 : ((a == AR) ? 2 : 0);
      ms = 0;
    end else if (a == seq_at(ms)) ms++;
    else ms = 0;
    ml = a;
    mv = 1;
    if (k != 0) begin ms = 0; mv = 0; end
    return k;
  endfunction

  task automatic bus(input logic [14:0] a, input bit wr, output bit st);
    bit b0;
    @(negedge clk);
    b0 = busy; addr = a; we_n = !wr; ce_n = 0;
    @(negedge clk);
    st = busy && !b0; ce_n = 1; we_n = 1;
  endtask

  task automatic seq6(input logic [14:0] fin, input bit wr_mix, output bit early, output bit st);
    bit s;
    early = 0;
    for (int i = 0; i < 5; i++) begin
      bus(seq_at(i), 0, s);
      early |= s;
      if (wr_mix) begin bus(15'h1111, 1, s); early |= s; end
    end
    bus(fin, 0, st);
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sync_read();
    bit s;
    bus(15'h0000, 0, s);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    bit e, s;
    int x0;
    repeat (3) @(negedge clk);
    chk(!busy && !done_store && !done_recall, "R10 reset idle", busy, 0);
    chk(wr_block, "R9 blocked at reset, supply low", wr_block, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy, "R7 no transfer before supply rise", busy, 0);

    // R7 power-up recall
    x0 = xfers; vcc_ok = 1;
    @(negedge clk);
    chk(busy && wr_block, "R7 recall starts on rise", busy, 1);
    settle();
    chk(xfers == x0 + 1 && last_len == RC && last_kind == 2, "R7 R4 power-up recall length", last_len, RC);
    chk(!wr_block, "R9 writes allowed when idle and supply good", wr_block, 0);

    // R1 software store, R1 software recall
    sync_read(); x0 = xfers;
    seq6(AS, 0, e, s);
    chk(!e && s, "R1 store starts on sixth read", s, 1);
    settle();
    chk(last_len == SC && last_kind == 1, "R1 R4 store length/kind", last_len, SC);
    sync_read();
    seq6(AR, 0, e, s);
    chk(!e && s, "R1 recall starts on sixth read", s, 1);
    settle();
    chk(last_len == RC && last_kind == 2, "R1 R4 recall length/kind", last_len, RC);

    // R2 writes interleaved
    sync_read();
    seq6(AS, 1, e, s);
    chk(!e && s, "R2 writes do not disturb sequence", s, 1);
    settle();
    chk(last_kind == 1, "R2 store kind", last_kind, 1);

    // R3 repeated address abort and off-sequence address
    sync_read(); x0 = xfers;
    bus(A0, 0, s); bus(A1, 0, s); bus(A1, 0, s);
    bus(A2, 0, s); bus(A3, 0, s); bus(A4, 0, s); bus(AS, 0, s);
    repeat (3) @(negedge clk);
    chk(!busy && xfers == x0, "R3 repeated address aborts", xfers - x0, 0);
    bus(A0, 0, s); bus(A1, 0, s); bus(15'h1234, 0, s);
    bus(A2, 0, s); bus(A3, 0, s); bus(A4, 0, s); bus(AR, 0, s);
    repeat (3) @(negedge clk);
    chk(!busy && xfers == x0, "R3 foreign address aborts", xfers - x0, 0);

    // R5 bus ignored during transfer
    sync_read(); x0 = xfers;
    seq6(AS, 0, e, s);
    seq6(AR, 0, e, s);
    chk(busy, "R5 still busy during ignored sequence", busy, 1);
    settle();
    repeat (5) @(negedge clk);
    chk(xfers == x0 + 1 && last_len == SC, "R5 single transfer", xfers - x0, 1);

    // R8 clean brown-out: no store; R9 blocked
    x0 = xfers; vcc_ok = 0;
    repeat (20) @(negedge clk);
    chk(xfers == x0 && !busy, "R8 clean brown-out skips store", xfers - x0, 0);
    chk(wr_block, "R9 blocked while supply low", wr_block, 1);
    bus(15'h0222, 1, s);

    // R6 store inhibited low, recall allowed
    sync_read();
    seq6(AS, 0, e, s);
    repeat (3) @(negedge clk);
    chk(!s && xfers == x0, "R6 store inhibited with supply low", s, 0);
    sync_read();
    seq6(AR, 0, e, s);
    chk(s, "R6 recall runs with supply low", s, 1);
    settle();
    chk(last_kind == 2 && last_len == RC, "R6 recall kind", last_kind, 2);

    // R11 supply rise coincident with sixth recall read
    sync_read(); x0 = xfers;
    for (int i = 0; i < 5; i++) bus(seq_at(i), 0, s);
    @(negedge clk);
    addr = AR; we_n = 1; ce_n = 0; vcc_ok = 1;
    @(negedge clk);
    ce_n = 1;
    settle();
    repeat (5) @(negedge clk);
    chk(xfers == x0 + 1 && last_kind == 2 && last_len == RC, "R11 one recall on collision", xfers - x0, 1);

    // R8 dirty brown-out store, R11 rise during store deferred
    bus(15'h0333, 1, s);
    x0 = xfers; vcc_ok = 0;
    @(negedge clk);
    chk(busy, "R8 dirty brown-out starts store", busy, 1);
    repeat (5) @(negedge clk);
    vcc_ok = 1;
    repeat (SC + RC + 10) @(negedge clk);
    chk(xfers == x0 + 2, "R11 deferred recall follows", xfers - x0, 2);
    chk(prev_kind == 1 && last_kind == 2 && last_len == RC, "R8 R11 store then recall", prev_kind * 10 + last_kind, 12);

    // random phase
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    settle();
    ms = 0; mv = 0;
    void'($urandom(32'h5EED));
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      logic [14:0] a;
      int k;
      if (r < 10) begin
        bus(15'($urandom), 1, s);
        chk(!s, "R2 random write starts nothing", s, 0);
      end else begin
        if (r < 70) a = (ms == 5) ? (($urandom_range(0, 1) == 1) ? AS : AR) : seq_at(ms);
        else if (r < 80 && mv) a = ml;
        else if (r < 90) a = seq_at($urandom_range(0, 4));
        else a = 15'($urandom);
        k = model_read(a);
        x0 = xfers;
        bus(a, 0, s);
        chk(s == (k != 0), "R1 R3 random start prediction", s, k != 0);
        if (k != 0) begin
          settle();
          chk(last_kind == k && last_len == (k == 1 ? SC : RC), "R4 random transfer", last_kind, k);
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule